// File: doc/BRIEF.md
# Single-Cycle Five-Instruction Processor Core

This block is a small processor that completes one instruction per clock. Each cycle it presents the program counter on the instruction port and decodes the 32-bit word that comes back. It reads up to three of its sixteen 32-bit registers and forms a second operand from either a register or a 19-bit immediate. The ALU then produces a sum or a bitwise AND. On the next rising edge the new program counter, any register result and any memory write all take effect together.

Five operations are supported: load, store, add, AND and a conditional branch with an absolute target. Both memory ports are treated as ideal, which means the read data is combinational on the address and the write happens on the clock edge. The core is meant to run short programs held in memories outside the block. Opcodes with no meaning are skipped and only advance the program counter.

Top module: `subset_cpu`

## Requirements
- R1: A high `rst` at a rising edge sets the program counter (`imem_addr`) to 0 at that edge.
- R2: The instruction word has these fields. Bits 31:28 hold the opcode, with 0001 load, 0011 store, 0101 add, 0111 AND and 1110 branch. Bits 27:24 are rd, which also serves as the branch condition. Bits 23:20 are ra. Bit 19 is the immediate select. Bits 18:0 are imm, and bits 3:0 are rb.
- R3: Add writes R[ra] + operand into R[rd]. For add, the operand is imm sign-extended when bit 19 is 1, and R[rb] when bit 19 is 0.
- R4: AND writes R[ra] & operand into R[rd]. For AND, the operand is imm zero-extended when bit 19 is 1, and R[rb] when bit 19 is 0.
- R5: Load drives `dmem_addr` = R[ra] + sign-extended operand and writes `dmem_rdata` into R[rd].
- R6: Store drives `dmem_we` = 1, `dmem_addr` = R[ra] + sign-extended operand and `dmem_wdata` = R[rd]. It changes no register.
- R7: Every opcode except branch sets the next PC to PC + 4.
- R8: A branch with condition 0 is always taken. Its target is the sign-extended operand itself, not an offset from the PC.
- R9: A branch with condition 1 is taken when R[ra] is zero. Otherwise the next PC is PC + 4.
- R10: A branch with any other condition value is taken when bit 31 of R[ra] is set. Otherwise the next PC is PC + 4.
- R11: An undefined opcode writes no register and no memory, and advances the PC by 4.
- R12: `dmem_we` is 1 exactly when the current instruction is a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Program counter, the address of the current instruction |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data memory address, R[ra] + operand |
| dmem_wdata | output | 32 | Store data, R[rd] |
| dmem_we | output | 1 | Data memory write enable |
| dmem_rdata | input | 32 | Data memory read data at `dmem_addr` |

## Verification
A short program seeds the registers from an unknown starting state using an AND with a zero immediate. It then uses the same immediate pattern once sign-extended (add) and once zero-extended (AND), so the two extension rules give visibly different values. Stores with register and immediate offsets expose the address sum and the third read port, and a load followed by a store shows that the load result reached the register file. Branches cover each condition both taken and not taken, with targets from an immediate, a register and a negative immediate. An undefined opcode aimed at a register that is stored afterwards shows that it changed nothing.

// File: rtl/subset_cpu_pkg.sv
package subset_cpu_pkg;

  localparam int OP_W   = 4;
  localparam int IMM_W  = 19;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD   = 4'b0001,
    OP_STORE  = 4'b0011,
    OP_ADD    = 4'b0101,
    OP_AND    = 4'b0111,
    OP_BRANCH = 4'b1110
  } opcode_e;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_AND = 1'b1
  } alu_fn_e;

  typedef struct packed {
    logic    reg_we;
    logic    mem_we;
    logic    load;
    logic    branch;
    logic    sext;
    alu_fn_e fn;
  } ctrl_t;

endpackage

// File: rtl/scc_decode.sv
module scc_decode
  import subset_cpu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int REG_W = 4
) (
  input  logic [XLEN-1:0]  instr,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] rd,
  output logic [REG_W-1:0] ra,
  output logic [REG_W-1:0] rb,
  output logic             use_imm,
  output logic [IMM_W-1:0] imm
);

  // R2: field positions
  assign rd      = instr[24 +: REG_W];
  assign ra      = instr[20 +: REG_W];
  assign use_imm = instr[IMM_W];
  assign imm     = instr[IMM_W-1:0];
  assign rb      = instr[REG_W-1:0];

  always_comb begin
    ctrl = '{reg_we: 1'b0, mem_we: 1'b0, load: 1'b0, branch: 1'b0,
             sext: 1'b1, fn: ALU_ADD};
    case (instr[XLEN-1 -: OP_W])
      OP_LOAD: begin
        ctrl.reg_we = 1'b1;
        ctrl.load   = 1'b1;
      end
      OP_STORE:  ctrl.mem_we = 1'b1;
      OP_ADD:    ctrl.reg_we = 1'b1;
      OP_AND: begin
        ctrl.reg_we = 1'b1;
        ctrl.sext   = 1'b0;
        ctrl.fn     = ALU_AND;
      end
      OP_BRANCH: ctrl.branch = 1'b1;
      default: ; // R11: no-op
    endcase
  end

endmodule

// File: rtl/scc_regfile.sv
module scc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic [REG_W-1:0] a_addr,
  output logic [XLEN-1:0]  a_data,
  input  logic [REG_W-1:0] b_addr,
  output logic [XLEN-1:0]  b_data,
  input  logic [REG_W-1:0] c_addr,
  output logic [XLEN-1:0]  c_data,
  input  logic             c_we,
  input  logic [XLEN-1:0]  c_wdata
);

  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (c_we) mem[c_addr] <= c_wdata;
  end

  assign a_data = mem[a_addr];
  assign b_data = mem[b_addr];
  assign c_data = mem[c_addr];

endmodule

// File: rtl/scc_alu.sv
module scc_alu
  import subset_cpu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_fn_e         fn,
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  output logic [XLEN-1:0] y
);

  always_comb begin
    case (fn)
      ALU_AND: y = lhs & rhs;
      default: y = lhs + rhs;
    endcase
  end

endmodule

// File: rtl/scc_branch.sv
module scc_branch #(
  parameter int XLEN  = 32,
  parameter int REG_W = 4
) (
  input  logic [REG_W-1:0] cond,
  input  logic [XLEN-1:0]  test_val,
  output logic             taken
);

  logic is_zero;
  logic is_neg;

  assign is_zero = (test_val == '0);
  assign is_neg  = test_val[XLEN-1];

  always_comb begin
    case (cond)
      REG_W'(0): taken = 1'b1;     // R8
      REG_W'(1): taken = is_zero;  // R9
      default:   taken = is_neg;   // R10
    endcase
  end

endmodule

// File: rtl/subset_cpu.sv
module subset_cpu
  import subset_cpu_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NREG     = 16,
  parameter int PC_STEP  = 4,
  localparam int REG_W   = $clog2(NREG),
  localparam int EXT_W   = XLEN - IMM_W
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  ctrl_t            ctrl;
  logic [REG_W-1:0] rd, ra, rb;
  logic             use_imm;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  ra_val, rb_val, rc_val;
  logic [XLEN-1:0]  imm_ext, operand, alu_y, wb_val, pc_q, pc_d;
  logic             taken;

  scc_decode #(.XLEN(XLEN), .REG_W(REG_W)) u_dec (
    .instr(imem_rdata), .ctrl(ctrl), .rd(rd), .ra(ra), .rb(rb),
    .use_imm(use_imm), .imm(imm)
  );

  scc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk),
    .a_addr(ra), .a_data(ra_val),
    .b_addr(rb), .b_data(rb_val),
    .c_addr(rd), .c_data(rc_val),
    .c_we(ctrl.reg_we && !rst), .c_wdata(wb_val)
  );

  // R3/R4: per-opcode extension of the immediate
  assign imm_ext = ctrl.sext ? {{EXT_W{imm[IMM_W-1]}}, imm}
                             : {{EXT_W{1'b0}}, imm};
  assign operand = use_imm ? imm_ext : rb_val;

  scc_alu #(.XLEN(XLEN)) u_alu (
    .fn(ctrl.fn), .lhs(ra_val), .rhs(operand), .y(alu_y)
  );

  scc_branch #(.XLEN(XLEN), .REG_W(REG_W)) u_br (
    .cond(rd), .test_val(ra_val), .taken(taken)
  );

  assign wb_val = ctrl.load ? dmem_rdata : alu_y;
  assign pc_d   = (ctrl.branch && taken) ? operand : pc_q + XLEN'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rc_val;
  assign dmem_we    = ctrl.mem_we;

endmodule

// File: rtl/subset_cpu_chk.sv
module subset_cpu_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [3:0]  op,
  input logic [3:0]  cond,
  input logic        use_imm,
  input logic [18:0] imm,
  input logic        dmem_we
);

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> imem_addr == 32'h0);

  // R7
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (op != 4'b1110) |=> imem_addr == $past(imem_addr) + 32'd4);

  // R8
  abs_target_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 4'b1110 && cond == 4'd0 && use_imm)
      |=> imem_addr == $past({{13{imm[18]}}, imm}));

  // R12
  we_only_store_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> op == 4'b0011);

  // R6
  store_we_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 4'b0011) |-> dmem_we);

endmodule

bind subset_cpu subset_cpu_chk u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr),
  .op(imem_rdata[31:28]), .cond(imem_rdata[27:24]),
  .use_imm(imem_rdata[19]), .imm(imem_rdata[18:0]),
  .dmem_we(dmem_we)
);

// File: tb/subset_cpu_tb.sv
`timescale 1ns/1ps
module subset_cpu_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  subset_cpu u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  // data memory model: read value derived from the address
  assign dmem_rdata = {dmem_addr[15:0], 16'h5A5A};

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] pc;
    logic        we;
    logic        chk;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{32'h7118_0000, 32'h00, 1'b0, 1'b0, 32'h0,       32'h0,        8'd4},  // R4 r1=0
    '{32'h521F_FFFC, 32'h04, 1'b0, 1'b0, 32'h0,       32'h0,        8'd3},  // R3 r2=-4
    '{32'h732F_FFFC, 32'h08, 1'b0, 1'b0, 32'h0,       32'h0,        8'd4},  // R4 r3=zext
    '{32'h3318_0010, 32'h0C, 1'b1, 1'b1, 32'h10,      32'h0007FFFC, 8'd6},  // R6
    '{32'h3230_0002, 32'h10, 1'b1, 1'b1, 32'h0007FFF8,32'hFFFFFFFC, 8'd6},  // R6 reg offset
    '{32'h1418_0008, 32'h14, 1'b0, 1'b1, 32'h08,      32'h0,        8'd5},  // R5 load
    '{32'h3418_0000, 32'h18, 1'b1, 1'b1, 32'h0,       32'h00085A5A, 8'd5},  // R5 loaded value
    '{32'hE138_0100, 32'h1C, 1'b0, 1'b0, 32'h0,       32'h0,        8'd9},  // R9 not taken
    '{32'hE118_0040, 32'h20, 1'b0, 1'b0, 32'h0,       32'h0,        8'd9},  // R9 taken
    '{32'hE728_0080, 32'h40, 1'b0, 1'b0, 32'h0,       32'h0,        8'd10}, // R10 taken
    '{32'hE738_0200, 32'h80, 1'b0, 1'b0, 32'h0,       32'h0,        8'd10}, // R10 not taken
    '{32'h5518_00C0, 32'h84, 1'b0, 1'b0, 32'h0,       32'h0,        8'd7},  // R7
    '{32'hE030_0005, 32'h88, 1'b0, 1'b0, 32'h0,       32'h0,        8'd8},  // R8 reg target
    '{32'hF128_0123, 32'hC0, 1'b0, 1'b0, 32'h0,       32'h0,        8'd11}, // R11 undefined
    '{32'h3118_0004, 32'hC4, 1'b1, 1'b1, 32'h04,      32'h0,        8'd11}, // R11 r1 kept
    '{32'h7740_0002, 32'hC8, 1'b0, 1'b0, 32'h0,       32'h0,        8'd4},  // R4 reg operand
    '{32'h3718_0020, 32'hCC, 1'b1, 1'b1, 32'h20,      32'h00085A58, 8'd4}   // R4 result
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    imem_rdata = 32'h0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(imem_addr == 32'h0, "R1 reset pc", imem_addr, 32'h0);
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      imem_rdata = VEC[k].instr;
      #1;
      check(imem_addr == VEC[k].pc, $sformatf("R%0d pc step %0d", VEC[k].req, k),
            imem_addr, VEC[k].pc);
      // R12: write enable only for stores
      check(dmem_we == VEC[k].we, $sformatf("R12 we step %0d", k),
            {31'h0, dmem_we}, {31'h0, VEC[k].we});
      if (VEC[k].chk) begin
        check(dmem_addr == VEC[k].addr, $sformatf("R%0d addr step %0d", VEC[k].req, k),
              dmem_addr, VEC[k].addr);
        if (VEC[k].we)
          check(dmem_wdata == VEC[k].wdata,
                $sformatf("R%0d wdata step %0d", VEC[k].req, k),
                dmem_wdata, VEC[k].wdata);
      end
      @(negedge clk);
    end
    // R8: always-taken branch, negative immediate gives absolute target
    imem_rdata = 32'hE01F_FFF0;
    check(imem_addr == 32'hD0, "R7 pc before branch", imem_addr, 32'hD0);
    @(negedge clk);
    check(imem_addr == 32'hFFFF_FFF0, "R8 negative target", imem_addr, 32'hFFFF_FFF0);
    // R1: reset in mid-run
    imem_rdata = 32'h5518_0000;
    rst = 1'b1;
    @(negedge clk);
    check(imem_addr == 32'h0, "R1 mid-run reset", imem_addr, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(imem_addr == 32'h4, "R7 after reset", imem_addr, 32'h4);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule